// File: doc/BRIEF.md
# Programmable-Timing External Memory Interface

This block connects a byte-wide internal bus to an asynchronous external memory or peripheral. The external side has an 8-bit data path, a set of active-low chip-enables, an active-low output-enable and an active-low write-enable. Each internal request is turned into one external access. An access walks through three timed phases: address setup, strobe and hold. The length of each phase comes from separate read and write timing inputs, counted in bus clocks.

The internal master raises a request and holds it. While the external access is in progress, the block keeps the master stalled. Completion is shown by a one-cycle done pulse. The master then drops its request. Several external devices can share the address and data pins, because each request names the chip-enable it uses. The number of live address lines can be set from 18 to 32, and the lines above that width are held low.

Top module: `ext_mem_bridge`

## Requirements
- R1: After reset every chip-enable, the output-enable and the write-enable are high, the data-out enable is low, and the done pulse is low. While no request is presented, all of them keep those values.
- R2: An access activates its chip-enable for a contiguous run of setup, then strobe, then hold cycles. The setup and hold lengths are the programmed values (0 to 15), and the phases always occur in that order.
- R3: A programmed strobe length of 0 is treated as 1, so every access has at least one strobe cycle.
- R4: A read takes its three lengths only from the read timing inputs and pulses only the output-enable. A write takes its lengths only from the write timing inputs and pulses only the write-enable. The output-enable and the write-enable are never low together.
- R5: Read data is sampled from the data-in pins at the clock edge that ends the last strobe cycle. It appears on the read-data output from the done cycle onward and is held until the next read completes, so a write leaves it unchanged.
- R6: On a write, the data-out enable is high and the data-out pins carry the write byte on every cycle of setup, strobe and hold. The data-out enable is low at all other times and for the whole of a read.
- R7: During an access, the address pins carry the request address with every bit at or above the configured width forced to 0. A width below 18 acts as 18, and a width above 32 acts as 32.
- R8: The done pulse is high for exactly one cycle, namely the cycle right after the last active cycle. The stall output equals request-valid AND NOT done.
- R9: Only the chip-enable whose index equals the request's select field goes low. All other chip-enables stay high.
- R10: A zero setup or hold length removes that phase entirely: the strobe begins in the first active cycle (zero setup), or the access ends with the strobe (zero hold).
- R11: The timing values, address width, address, data and select are captured when the request is accepted. Changing the configuration inputs during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Internal request present, held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 1 | Index of the chip-enable to use |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 8 | Write byte |
| req_wait | output | 1 | Stall to the internal master |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Captured read byte |
| cfg_addr_lines | input | 6 | Number of live external address lines |
| cfg_rd_setup | input | 4 | Read setup length in clocks |
| cfg_rd_strobe | input | 4 | Read strobe length in clocks |
| cfg_rd_hold | input | 4 | Read hold length in clocks |
| cfg_wr_setup | input | 4 | Write setup length in clocks |
| cfg_wr_strobe | input | 4 | Write strobe length in clocks |
| cfg_wr_hold | input | 4 | Write hold length in clocks |
| mem_addr | output | 32 | External address pins |
| mem_ce_n | output | 2 | Active-low chip-enables |
| mem_oe_n | output | 1 | Active-low output-enable |
| mem_we_n | output | 1 | Active-low write-enable |
| mem_dq_out | output | 8 | External data driven on writes |
| mem_dq_oe | output | 1 | Drive enable for the external data pins |
| mem_dq_in | input | 8 | External data returned on reads |

## Verification
Reads and writes are alternated, and each one is given deliberately wrong timing on the unused direction's inputs. A phase length taken from the wrong register therefore shows up as a miscounted phase. The memory model returns a different byte on each strobe cycle, which separates sampling at the last strobe cycle from sampling earlier. Patterns with zero setup, zero strobe and zero hold are set against maximal lengths, widths below and above the legal range are set against interior widths, and all-ones addresses show any bit that leaks above the width. Two accesses change the configuration in mid-flight to show that the values were captured.

// File: rtl/emi_pkg.sv
package emi_pkg;

  localparam int EMI_CNT_W = 4;
  localparam int EMI_AW    = 32;
  localparam int EMI_AW_MIN = 18;
  localparam int EMI_WW    = 6;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [EMI_CNT_W-1:0] setup;
    logic [EMI_CNT_W-1:0] strobe;
    logic [EMI_CNT_W-1:0] hold;
  } timing_t;

  // strobe phase never shorter than one clock
  function automatic logic [EMI_CNT_W-1:0] strobe_len(input logic [EMI_CNT_W-1:0] p);
    return (p == '0) ? EMI_CNT_W'(1) : p;
  endfunction

  // legal live address width
  function automatic int clamp_width(input logic [EMI_WW-1:0] w);
    int cw;
    cw = int'(w);
    if (cw < EMI_AW_MIN) cw = EMI_AW_MIN;
    if (cw > EMI_AW) cw = EMI_AW;
    return cw;
  endfunction

  // bit i set when address line i is live
  function automatic logic [EMI_AW-1:0] width_mask(input logic [EMI_WW-1:0] w);
    logic [EMI_AW-1:0] m;
    int cw;
    cw = clamp_width(w);
    for (int i = 0; i < EMI_AW; i++) m[i] = (i < cw);
    return m;
  endfunction

endpackage

// File: rtl/emi_seq.sv
module emi_seq
  import emi_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  timing_t tm_in,
  output phase_e  phase,
  output logic    strobe_last,
  output logic    finish
);

  phase_e               phase_q, phase_d;
  logic [EMI_CNT_W-1:0] cnt_q, cnt_d;
  timing_t              tm_q, tm_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    tm_d    = tm_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          tm_d = tm_in;
          if (tm_in.setup != '0) begin
            phase_d = PH_SETUP;
            cnt_d   = tm_in.setup - 1'b1;
          end else begin
            phase_d = PH_STROBE;
            cnt_d   = strobe_len(tm_in.strobe) - 1'b1;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_STROBE;
          cnt_d   = strobe_len(tm_q.strobe) - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          if (tm_q.hold != '0) begin
            phase_d = PH_HOLD;
            cnt_d   = tm_q.hold - 1'b1;
          end else begin
            phase_d = PH_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) phase_d = PH_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tm_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      tm_q    <= tm_d;
    end
  end

  assign phase       = phase_q;
  assign strobe_last = (phase_q == PH_STROBE) && (cnt_q == '0);
  assign finish      = (phase_q != PH_IDLE) && (phase_d == PH_IDLE);

  // R2
  setup_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP) |=> (phase_q == PH_SETUP || phase_q == PH_STROBE));

  // R3
  strobe_follows_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP && cnt_q == '0) |=> (phase_q == PH_STROBE));

  // R2
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD) |-> ($past(phase_q) == PH_STROBE || $past(phase_q) == PH_HOLD));

endmodule

// File: rtl/emi_pins.sv
module emi_pins
  import emi_pkg::*;
#(
  parameter int NUM_CS = 2,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              is_write,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic [EMI_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [EMI_AW-1:0] mem_addr,
  output logic [NUM_CS-1:0] mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [7:0]        mem_dq_out,
  output logic              mem_dq_oe
);

  logic active, strobing;

  assign active   = (phase != PH_IDLE);
  assign strobing = (phase == PH_STROBE);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign mem_ce_n[g] = !(active && (cs_sel == CS_W'(g)));
  end

  assign mem_oe_n   = !(strobing && !is_write);
  assign mem_we_n   = !(strobing && is_write);
  assign mem_dq_oe  = active && is_write;
  assign mem_dq_out = wdata;
  assign mem_addr   = addr;

  // R9
  single_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_ce_n));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n || mem_we_n));

  // R6
  drive_only_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && $countones(~mem_ce_n) == 1));

endmodule

// File: rtl/ext_mem_bridge.sv
module ext_mem_bridge
  import emi_pkg::*;
#(
  parameter int NUM_CS = 2,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [CS_W-1:0]      req_cs,
  input  logic [EMI_AW-1:0]    req_addr,
  input  logic [7:0]           req_wdata,
  output logic                 req_wait,
  output logic                 req_done,
  output logic [7:0]           req_rdata,
  input  logic [EMI_WW-1:0]    cfg_addr_lines,
  input  logic [EMI_CNT_W-1:0] cfg_rd_setup,
  input  logic [EMI_CNT_W-1:0] cfg_rd_strobe,
  input  logic [EMI_CNT_W-1:0] cfg_rd_hold,
  input  logic [EMI_CNT_W-1:0] cfg_wr_setup,
  input  logic [EMI_CNT_W-1:0] cfg_wr_strobe,
  input  logic [EMI_CNT_W-1:0] cfg_wr_hold,
  output logic [EMI_AW-1:0]    mem_addr,
  output logic [NUM_CS-1:0]    mem_ce_n,
  output logic                 mem_oe_n,
  output logic                 mem_we_n,
  output logic [7:0]           mem_dq_out,
  output logic                 mem_dq_oe,
  input  logic [7:0]           mem_dq_in
);

  phase_e            phase;
  logic              strobe_last, finish, accept;
  logic              done_q, write_q;
  logic [CS_W-1:0]   cs_q;
  logic [EMI_AW-1:0] addr_q;
  logic [7:0]        wdata_q, rdata_q;
  timing_t           tm_sel;

  assign accept = req_valid && (phase == PH_IDLE) && !done_q;
  assign tm_sel = req_write ? timing_t'{cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold}
                            : timing_t'{cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold};

  emi_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .tm_in       (tm_sel),
    .phase       (phase),
    .strobe_last (strobe_last),
    .finish      (finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      cs_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        write_q <= req_write;
        cs_q    <= req_cs;
        addr_q  <= req_addr & width_mask(cfg_addr_lines);
        wdata_q <= req_wdata;
      end
      if (strobe_last && !write_q) rdata_q <= mem_dq_in;
      done_q <= finish;
    end
  end

  emi_pins #(.NUM_CS(NUM_CS)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .is_write   (write_q),
    .cs_sel     (cs_q),
    .addr       (addr_q),
    .wdata      (wdata_q),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  assign req_done  = done_q;
  assign req_wait  = req_valid && !done_q;
  assign req_rdata = rdata_q;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  // R5
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_last && !mem_oe_n) |=> (req_rdata == $past(mem_dq_in)));

  // R7
  upper_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((mem_addr & ~width_mask($past(cfg_addr_lines))) == '0));

  // R8
  done_after_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_done) |-> ($past(mem_ce_n) != '1));

endmodule

// File: tb/ext_mem_bridge_tb_top.sv
module ext_mem_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [0:0]  req_cs = '0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_wait, req_done;
  logic [7:0]  req_rdata;
  logic [5:0]  cfg_addr_lines = 6'd18;
  logic [3:0]  cfg_rd_setup = '0, cfg_rd_strobe = '0, cfg_rd_hold = '0;
  logic [3:0]  cfg_wr_setup = '0, cfg_wr_strobe = '0, cfg_wr_hold = '0;
  logic [31:0] mem_addr;
  logic [1:0]  mem_ce_n;
  logic        mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;

  int checks = 0;
  int failures = 0;
  logic [7:0] last_read = '0;

  always #5 clk = ~clk;

  ext_mem_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wait(req_wait), .req_done(req_done), .req_rdata(req_rdata),
    .cfg_addr_lines(cfg_addr_lines),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  typedef struct packed {
    logic        wr;
    logic        cs;
    logic [5:0]  aw;
    logic [31:0] addr;
    logic [7:0]  wd;
    logic [3:0]  s;
    logic [3:0]  p;
    logic [3:0]  h;
    logic        chg;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 6'd18, 32'hFFFF_FFFF, 8'h00, 4'd1,  4'd1,  4'd1,  1'b0},
    '{1'b1, 1'b1, 6'd18, 32'h1234_5678, 8'h3C, 4'd2,  4'd3,  4'd1,  1'b0},
    '{1'b0, 1'b1, 6'd32, 32'hDEAD_BEEF, 8'h00, 4'd0,  4'd0,  4'd0,  1'b0},
    '{1'b1, 1'b0, 6'd24, 32'hABCD_EF01, 8'hA5, 4'd0,  4'd2,  4'd0,  1'b0},
    '{1'b0, 1'b0, 6'd5,  32'h8765_4321, 8'h00, 4'd3,  4'd4,  4'd2,  1'b0},
    '{1'b1, 1'b1, 6'd40, 32'hFEDC_BA98, 8'h0F, 4'd15, 4'd15, 4'd15, 1'b0},
    '{1'b0, 1'b0, 6'd20, 32'h0F0F_F0F0, 8'h00, 4'd2,  4'd3,  4'd1,  1'b1},
    '{1'b1, 1'b0, 6'd31, 32'h8000_0001, 8'hFF, 4'd1,  4'd0,  4'd3,  1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] live_lines(input logic [5:0] w);
    int n;
    n = (w < 6'd18) ? 18 : ((w > 6'd32) ? 32 : int'(w));
    if (n == 32) return 32'hFFFF_FFFF;
    return (32'h1 << n) - 32'h1;
  endfunction

  task automatic run_access(input vec_t v);
    int cs_n = 0, cp_n = 0, ch_n = 0, k = 0;
    bit in_strobe_seen = 0, got_done = 0;
    logic [3:0] pe;
    logic [7:0] base;
    logic [31:0] exp_addr;
    pe = (v.p == 4'd0) ? 4'd1 : v.p;
    base = v.addr[7:0] ^ 8'hA5;
    exp_addr = v.addr & live_lines(v.aw);
    @(negedge clk);
    cfg_addr_lines = v.aw;
    if (v.wr) begin
      {cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold} = {v.s, v.p, v.h};
      {cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold} = {4'd7, 4'd6, 4'd5};
    end else begin
      {cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold} = {v.s, v.p, v.h};
      {cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold} = {4'd7, 4'd6, 4'd5};
    end
    req_write = v.wr; req_cs = v.cs; req_addr = v.addr; req_wdata = v.wd;
    req_valid = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (req_done) begin got_done = 1; break; end
      chk(mem_ce_n[v.cs] == 1'b0, "R2", "ce contiguous", {31'd0, mem_ce_n[v.cs]}, 32'd0);
      chk(mem_ce_n[!v.cs] == 1'b1, "R9", "other ce", {31'd0, mem_ce_n[!v.cs]}, 32'd1);
      chk(req_wait == 1'b1, "R8", "stall during access", {31'd0, req_wait}, 32'd1);
      chk(mem_addr == exp_addr, "R7", "address pins", mem_addr, exp_addr);
      if (v.wr) begin
        chk(mem_oe_n == 1'b1, "R4", "oe idle on write", {31'd0, mem_oe_n}, 32'd1);
        chk(mem_dq_oe == 1'b1 && mem_dq_out == v.wd, "R6", "write drive",
            {23'd0, mem_dq_oe, mem_dq_out}, {23'd0, 1'b1, v.wd});
      end else begin
        chk(mem_we_n == 1'b1, "R4", "we idle on read", {31'd0, mem_we_n}, 32'd1);
        chk(mem_dq_oe == 1'b0, "R6", "no drive on read", {31'd0, mem_dq_oe}, 32'd0);
      end
      if ((v.wr && !mem_we_n) || (!v.wr && !mem_oe_n)) begin
        cp_n++; in_strobe_seen = 1;
      end else if (!in_strobe_seen) cs_n++;
      else ch_n++;
      if (!mem_oe_n) begin mem_dq_in = base + 8'(k); k++; end
      if (v.chg && i == 0) begin
        cfg_addr_lines = 6'd32;
        {cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold} = {4'd9, 4'd9, 4'd9};
        {cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold} = {4'd9, 4'd9, 4'd9};
      end
    end
    chk(got_done, "R8", "done seen", {31'd0, got_done}, 32'd1);
    chk(cs_n == int'(v.s), v.chg ? "R11" : "R2", "setup cycles", cs_n, {28'd0, v.s});
    chk(cp_n == int'(pe), (v.p == 0) ? "R3" : "R2", "strobe cycles", cp_n, {28'd0, pe});
    chk(ch_n == int'(v.h), (v.h == 0) ? "R10" : "R2", "hold cycles", ch_n, {28'd0, v.h});
    chk(req_wait == 1'b0, "R8", "stall released", {31'd0, req_wait}, 32'd0);
    chk(mem_dq_oe == 1'b0, "R6", "drive off after", {31'd0, mem_dq_oe}, 32'd0);
    if (v.wr) begin
      chk(req_rdata == last_read, "R5", "rdata held across write", {24'd0, req_rdata}, {24'd0, last_read});
    end else begin
      last_read = base + 8'(pe - 1);
      chk(req_rdata == last_read, "R5", "read capture", {24'd0, req_rdata}, {24'd0, last_read});
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_done == 1'b0, "R8", "done one cycle", {31'd0, req_done}, 32'd0);
    chk(mem_ce_n == 2'b11, "R1", "ce idle after", {30'd0, mem_ce_n}, 32'd3);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n == 2'b11 && mem_oe_n && mem_we_n, "R1", "strobes in reset",
        {28'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'hF);
    chk(!mem_dq_oe && !req_done, "R1", "drive/done in reset", {30'd0, mem_dq_oe, req_done}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(mem_ce_n == 2'b11 && mem_oe_n && mem_we_n && !mem_dq_oe && !req_done && !req_wait,
          "R1", "idle without request",
          {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_done}, 32'h3C);
    end
    for (int n = 0; n < NV; n++) run_access(VECS[n]);
    // R10 / R3: back-to-back shortest reads on alternating selects
    run_access('{1'b0, 1'b1, 6'd18, 32'h0000_0000, 8'h00, 4'd0, 4'd0, 4'd0, 1'b0});
    run_access('{1'b0, 1'b0, 6'd63, 32'h7FFF_FFFF, 8'h00, 4'd0, 4'd1, 4'd0, 1'b0});
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule